// File: doc/BRIEF.md
# Register-Indirect Conditional Branch Unit

This block resolves branches for a load-store RISC core whose branch targets always come from a general register. Each request carries the already-incremented sequential PC, a 3-bit condition code, and the two register operands read for the branch. One operand is the jump target. The other is the value that the condition tests for zero or sign. The block decides whether the branch is taken and produces the next PC. For the link flavour it also asks the register file to store the sequential PC into a named register.

Requests enter through a valid/ready channel. Results leave through a second valid/ready channel after one register stage. The upstream side may only treat a request as accepted in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result is presented with `rsp_valid` and holds every field unchanged until the consumer raises `rsp_ready`. Results come out in the order their requests were accepted, one result for each request.

Top module: `brunit_top`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: Condition code 3'b000 is never taken: `rsp_taken`=0 and `rsp_next_pc` equals the sequential PC of the request.
- R3: Condition code 3'b001 is always taken: `rsp_taken`=1 and `rsp_next_pc` equals the target operand.
- R4: Condition code 3'b010 is taken exactly when the tested operand equals zero.
- R5: Condition code 3'b011 is taken exactly when the tested operand is not zero.
- R6: Condition code 3'b100 is taken exactly when bit XLEN-1 of the tested operand is 0, so zero counts as non-negative.
- R7: Condition code 3'b101 is taken exactly when bit XLEN-1 of the tested operand is 1.
- R8: Condition codes 3'b110 and 3'b111 are treated like never: not taken, and the next PC is the sequential PC.
- R9: A link request (`req_link`=1) always raises `rsp_wr_en`, with `rsp_wr_idx` equal to `req_link_idx` and `rsp_wr_data` equal to the sequential PC. This holds for every condition code, including the never-taken ones.
- R10: A plain request (`req_link`=0) leaves `rsp_wr_en` at 0 for every condition code.
- R11: A taken branch loads the target operand presented with the request. This holds even when the same request writes a different link value, so the target is always the value read before the link write.
- R12: A result held with `rsp_ready`=0 keeps all fields stable. Every accepted request yields exactly one result, in acceptance order, whatever the back-pressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_link | input | 1 | 1 = branch-and-link, 0 = plain branch |
| req_cond | input | 3 | Condition code |
| req_seq_pc | input | XLEN | Already-incremented sequential PC |
| req_target | input | XLEN | Target register operand |
| req_test | input | XLEN | Tested register operand |
| req_link_idx | input | RIDX | Index of the register that receives the link value |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_taken | output | 1 | Branch taken |
| rsp_next_pc | output | XLEN | Next PC |
| rsp_wr_en | output | 1 | Register write request for the link value |
| rsp_wr_idx | output | RIDX | Register index for the link write |
| rsp_wr_data | output | XLEN | Link value (sequential PC) |

## Verification
The bench sweeps every condition code against zero, small positive, small negative, most-negative and most-positive test operands. A design that tested sign by magnitude, or that counted zero as negative, would misroute R6/R7 at the zero and extreme-value points. Every code is also sent in link form. A unit that gated the link write on the condition would drop the write for codes 000, 110 and 111, and one that routed the link value into the target would show a wrong next PC. A stretch of irregular consumer stalls checks that held results neither change nor get duplicated or lost.

// File: rtl/brunit_pkg.sv
package brunit_pkg;
  typedef enum logic [2:0] {
    COND_NEVER  = 3'b000,
    COND_ALWAYS = 3'b001,
    COND_ZERO   = 3'b010,
    COND_NZERO  = 3'b011,
    COND_NONNEG = 3'b100,
    COND_NEG    = 3'b101,
    COND_RSV6   = 3'b110,
    COND_RSV7   = 3'b111
  } cond_e;
endpackage

// File: rtl/brunit_cond.sv
module brunit_cond
  import brunit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] test_val,
  output logic            taken
);
  localparam int SIGN_BIT = XLEN - 1;

  logic is_zero;
  logic is_neg;

  assign is_zero = (test_val == '0);
  assign is_neg  = test_val[SIGN_BIT];

  always_comb begin
    unique case (cond_e'(cond))
      COND_ALWAYS: taken = 1'b1;
      COND_ZERO:   taken = is_zero;
      COND_NZERO:  taken = !is_zero;
      COND_NONNEG: taken = !is_neg;
      COND_NEG:    taken = is_neg;
      default:     taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brunit_resolve.sv
module brunit_resolve #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            taken,
  input  logic            link,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] target,
  input  logic [RIDX-1:0] link_idx,
  output logic [XLEN-1:0] next_pc,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data
);
  // Target operand was read with the request, so it is the pre-link value.
  assign next_pc = taken ? target : seq_pc;
  assign wr_en   = link;
  assign wr_idx  = link ? link_idx : '0;
  assign wr_data = link ? seq_pc : '0;
endmodule

// File: rtl/brunit_stage.sv
module brunit_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/brunit_top.sv
module brunit_top #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_link,
  input  logic [2:0]      req_cond,
  input  logic [XLEN-1:0] req_seq_pc,
  input  logic [XLEN-1:0] req_target,
  input  logic [XLEN-1:0] req_test,
  input  logic [RIDX-1:0] req_link_idx,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic [XLEN-1:0] rsp_next_pc,
  output logic            rsp_wr_en,
  output logic [RIDX-1:0] rsp_wr_idx,
  output logic [XLEN-1:0] rsp_wr_data
);
  localparam int PKT_W = 1 + XLEN + 1 + RIDX + XLEN;

  logic            c_taken;
  logic [XLEN-1:0] c_next_pc;
  logic            c_wr_en;
  logic [RIDX-1:0] c_wr_idx;
  logic [XLEN-1:0] c_wr_data;
  logic [PKT_W-1:0] pkt_in;
  logic [PKT_W-1:0] pkt_out;

  brunit_cond #(.XLEN(XLEN)) u_cond (
    .cond     (req_cond),
    .test_val (req_test),
    .taken    (c_taken)
  );

  brunit_resolve #(.XLEN(XLEN), .RIDX(RIDX)) u_resolve (
    .taken    (c_taken),
    .link     (req_link),
    .seq_pc   (req_seq_pc),
    .target   (req_target),
    .link_idx (req_link_idx),
    .next_pc  (c_next_pc),
    .wr_en    (c_wr_en),
    .wr_idx   (c_wr_idx),
    .wr_data  (c_wr_data)
  );

  assign pkt_in = {c_taken, c_next_pc, c_wr_en, c_wr_idx, c_wr_data};

  brunit_stage #(.W(PKT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pkt_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pkt_out)
  );

  assign {rsp_taken, rsp_next_pc, rsp_wr_en, rsp_wr_idx, rsp_wr_data} = pkt_out;
endmodule

// File: rtl/brunit_checker.sv
module brunit_checker #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_link,
  input logic [2:0]      req_cond,
  input logic [XLEN-1:0] req_seq_pc,
  input logic [XLEN-1:0] req_target,
  input logic [RIDX-1:0] req_link_idx,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_taken,
  input logic [XLEN-1:0] rsp_next_pc,
  input logic            rsp_wr_en,
  input logic [RIDX-1:0] rsp_wr_idx,
  input logic [XLEN-1:0] rsp_wr_data
);
  logic            cap_link;
  logic [2:0]      cap_cond;
  logic [XLEN-1:0] cap_seq;
  logic [XLEN-1:0] cap_tgt;
  logic [RIDX-1:0] cap_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_link <= 1'b0;
      cap_cond <= '0;
      cap_seq  <= '0;
      cap_tgt  <= '0;
      cap_idx  <= '0;
    end else if (req_valid && req_ready) begin
      cap_link <= req_link;
      cap_cond <= req_cond;
      cap_seq  <= req_seq_pc;
      cap_tgt  <= req_target;
      cap_idx  <= req_link_idx;
    end
  end

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_next_pc) && $stable(rsp_taken)
      && $stable(rsp_wr_en) && $stable(rsp_wr_data));

  assert_not_taken_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_taken |-> rsp_next_pc == cap_seq);

  assert_taken_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_taken |-> rsp_next_pc == cap_tgt);

  assert_never_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (cap_cond == 3'b000 || cap_cond[2:1] == 2'b11) |-> !rsp_taken);

  assert_always_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && cap_cond == 3'b001 |-> rsp_taken);

  assert_link_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && cap_link |-> rsp_wr_en && rsp_wr_data == cap_seq && rsp_wr_idx == cap_idx);

  assert_plain_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cap_link |-> !rsp_wr_en);
endmodule

bind brunit_top brunit_checker #(.XLEN(XLEN), .RIDX(RIDX)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_link     (req_link),
  .req_cond     (req_cond),
  .req_seq_pc   (req_seq_pc),
  .req_target   (req_target),
  .req_link_idx (req_link_idx),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_taken    (rsp_taken),
  .rsp_next_pc  (rsp_next_pc),
  .rsp_wr_en    (rsp_wr_en),
  .rsp_wr_idx   (rsp_wr_idx),
  .rsp_wr_data  (rsp_wr_data)
);

// File: tb/brunit_top_tb.sv
module brunit_top_tb;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef struct packed {
    logic            taken;
    logic [XLEN-1:0] next_pc;
    logic            wr_en;
    logic [RIDX-1:0] wr_idx;
    logic [XLEN-1:0] wr_data;
    logic            link;
    logic [2:0]      cond;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_link = 1'b0;
  logic [2:0]      req_cond = '0;
  logic [XLEN-1:0] req_seq_pc = '0;
  logic [XLEN-1:0] req_target = '0;
  logic [XLEN-1:0] req_test = '0;
  logic [RIDX-1:0] req_link_idx = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic            rsp_taken;
  logic [XLEN-1:0] rsp_next_pc;
  logic            rsp_wr_en;
  logic [RIDX-1:0] rsp_wr_idx;
  logic [XLEN-1:0] rsp_wr_data;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int got = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  brunit_top #(.XLEN(XLEN), .RIDX(RIDX)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_link(req_link),
    .req_cond(req_cond), .req_seq_pc(req_seq_pc), .req_target(req_target),
    .req_test(req_test), .req_link_idx(req_link_idx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
    .rsp_next_pc(rsp_next_pc), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
    .rsp_wr_data(rsp_wr_data)
  );

  function automatic string req_of(logic [2:0] c, logic l);
    string s;
    case (c)
      3'd0: s = "R2";
      3'd1: s = "R3";
      3'd2: s = "R4";
      3'd3: s = "R5";
      3'd4: s = "R6";
      3'd5: s = "R7";
      default: s = "R8";
    endcase
    return l ? {s, "/R9"} : {s, "/R10"};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it.
  task automatic send(logic l, logic [2:0] c, logic [XLEN-1:0] seq,
                      logic [XLEN-1:0] tgt, logic [XLEN-1:0] tst, logic [RIDX-1:0] idx);
    exp_t e;
    logic t;
    case (c)
      3'd1: t = 1'b1;
      3'd2: t = (tst == 0);
      3'd3: t = (tst != 0);
      3'd4: t = !tst[XLEN-1];
      3'd5: t = tst[XLEN-1];
      default: t = 1'b0;
    endcase
    e.taken = t;
    e.next_pc = t ? tgt : seq;
    e.wr_en = l;
    e.wr_idx = idx;
    e.wr_data = seq;
    e.link = l;
    e.cond = c;
    req_valid = 1'b1; req_link = l; req_cond = c; req_seq_pc = seq;
    req_target = tgt; req_test = tst; req_link_idx = idx;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(e);
    sent++;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Consumer back-pressure pattern.
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    rsp_ready = stall_mode ? (((cyc * 7) % 5) < 2) : 1'b1;
  end

  // Monitor: pops and compares each result as it is consumed.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R12", "unexpected result", 64'(rsp_next_pc), 64'd0);
      end else begin
        exp_t e;
        string r;
        e = q.pop_front();
        r = req_of(e.cond, e.link);
        got++;
        check(rsp_taken == e.taken, r, "taken", 64'(rsp_taken), 64'(e.taken));
        check(rsp_next_pc == e.next_pc, {r, "/R11"}, "next_pc", 64'(rsp_next_pc), 64'(e.next_pc));
        check(rsp_wr_en == e.wr_en, r, "wr_en", 64'(rsp_wr_en), 64'(e.wr_en));
        if (e.link) begin
          check(rsp_wr_idx == e.wr_idx, "R9", "wr_idx", 64'(rsp_wr_idx), 64'(e.wr_idx));
          check(rsp_wr_data == e.wr_data, "R9", "wr_data", 64'(rsp_wr_data), 64'(e.wr_data));
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] tv [5];
    tv[0] = 32'h0000_0000;
    tv[1] = 32'h0000_0005;
    tv[2] = 32'hFFFF_FFFD;
    tv[3] = 32'h8000_0000;
    tv[4] = 32'h7FFF_FFFF;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    // Sweep every code, link flavour and test operand.
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 8; c++)
        for (int k = 0; k < 5; k++)
          send(l[0], c[2:0], 32'h0000_1000 + 32'(c * 20 + k * 4),
               32'h0004_0000 + 32'(k * 16 + c), tv[k], 5'(c + k + 1));
    // R11: link with target value differing from the link value in the same request.
    send(1'b1, 3'b001, 32'h0000_2004, 32'h0000_9000, 32'h0, 5'd7);
    // R12: irregular back-pressure with back-to-back requests.
    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++)
      send(i[0], 3'(i % 8), 32'h0000_3000 + 32'(i * 4), 32'h0005_0000 + 32'(i),
           tv[i % 5], 5'(i));
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(got == sent, "R12", "results received", 64'(got), 64'(sent));
    check(q.size() == 0, "R12", "pending expected", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule